// File: doc/BRIEF.md
# Deferred-Exception Speculative Load Tracker

This block records what happened to loads that the compiler hoisted above a branch. Such a load never raises its fault when it completes. Instead, the tracker notes a deferred exception against the load's destination register. A later check operation on that register then decides the outcome. A clean register lets execution continue. A register carrying a deferred exception sends execution to a recovery address supplied with the check. A check on a register that no speculative load has written is a program error, and the block reports it.

Each architectural register has a small three-state machine: `IDLE` (no speculative result outstanding), `ARMED` (a speculative load completed without fault) and `DEFERRED` (a speculative load faulted). The transitions are named as follows:
- `LOAD_OK` moves a register from any state to `ARMED`.
- `LOAD_FAULT` moves a register from any state to `DEFERRED`.
- `PLAIN_WRITE` moves a register from any state to `IDLE`.
- `CHECK_CONSUME` moves a register from `ARMED` to `IDLE` when a check passes.

Within one cycle the events apply in a fixed order: the plain write first, then the speculative completion, then the check. A check therefore sees the effect of a same-cycle load or write.

A registered result stage holds one of four outcomes: `RES_NONE`, `RES_PASS`, `RES_REDIRECT` or `RES_ORPHAN`. The outcome appears on the outputs in the cycle after the check is presented, as a one-cycle strobe.

Top module: `spec_load_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every output is 0. After reset, every register is in `IDLE`, including any register that was armed or faulted before the reset.
- R2: A check on a register in `ARMED` raises `chk_pass` for exactly one cycle, in the cycle after the check. `chk_redirect` and `chk_orphan` stay low in that cycle.
- R3: A check on a register in `DEFERRED` raises `chk_redirect` for one cycle in the cycle after the check. In that cycle `redirect_addr` equals the check's `chk_target`. In every other cycle `redirect_addr` is 0.
- R4: A check on a register in `IDLE` raises `chk_orphan` for one cycle in the cycle after the check.
- R5: A plain write to a register returns it to `IDLE` and clears both its pending record and its deferred record.
- R6: A passing check consumes the pending record. A second check on that register, with no intervening load, reports orphan.
- R7: A redirecting check leaves the deferred record in place. Later checks keep redirecting until a plain write or a new speculative load arrives.
- R8: When a speculative completion and a check name the same register in the same cycle, the check sees the new state: a faulting load gives a redirect, and a clean load gives a pass.
- R9: When a plain write and a speculative completion name the same register in the same cycle, the speculative completion sets the register's final state.
- R10: When a plain write and a check name the same register in the same cycle, with no load to that register, the check reports orphan.
- R11: Events on one register never change the state or check outcome of another register.
- R12: In the cycle after each check, exactly one of `chk_pass`, `chk_redirect` and `chk_orphan` is 1. In the cycle after a cycle with no check, all three are 0.
- R13: A clean speculative load to a register in `DEFERRED` replaces the deferred record, so the next check passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_done_valid | input | 1 | A speculative load completes this cycle |
| ld_done_reg | input | REG_W (5) | Destination register of the completing load |
| ld_done_fault | input | 1 | The completing load detected an exception |
| wr_valid | input | 1 | A non-speculative register write happens this cycle |
| wr_reg | input | REG_W (5) | Register being written |
| chk_valid | input | 1 | A check operation is presented this cycle |
| chk_reg | input | REG_W (5) | Register tested by the check |
| chk_target | input | ADDR_W (32) | Recovery address used if the check redirects |
| chk_pass | output | 1 | One-cycle strobe: the checked speculative load was clean |
| chk_redirect | output | 1 | One-cycle strobe: a deferred exception was found |
| redirect_addr | output | ADDR_W (32) | Recovery address while `chk_redirect` is high, otherwise 0 |
| chk_orphan | output | 1 | One-cycle strobe: a check found no speculative record |

## Verification
Some behaviours are checked by assertions on every cycle:
- Exactly one outcome follows each check, and no outcome appears without a check.
- The redirect address matches the previous cycle's recovery target, and is zero outside a redirect.
- Same-cycle load-plus-check and write-plus-check collisions resolve in the stated order.
- Outputs stay quiet during reset.

Other behaviours need the bench's event sequences, because they depend on history held over many cycles:
- A pass consumes its record.
- A deferred record survives repeated checks.
- Writes and reloads overwrite earlier records.
- Reset wipes a faulted register.
- Registers stay independent of each other.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

    // Per-register speculation state
    typedef enum logic [1:0] {
        SLOT_IDLE     = 2'd0,
        SLOT_ARMED    = 2'd1,
        SLOT_DEFERRED = 2'd2
    } slot_state_e;

    // Registered outcome of a check
    typedef enum logic [1:0] {
        RES_NONE     = 2'd0,
        RES_PASS     = 2'd1,
        RES_REDIRECT = 2'd2,
        RES_ORPHAN   = 2'd3
    } chk_result_e;

endpackage

// File: rtl/reg_index_decoder.sv
module reg_index_decoder #(
    parameter int IDX_W = 5,
    localparam int N    = 1 << IDX_W
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     hit
);

    always_comb begin
        hit = '0;
        if (valid) begin
            hit[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/spec_slot.sv
module spec_slot
    import spec_trk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic        ld_hit,
    input  logic        ld_fault,
    input  logic        chk_hit,
    output slot_state_e merged_o
);

    slot_state_e state_q;
    slot_state_e merged;
    slot_state_e state_d;

    // The write applies first, then the speculative completion (R9)
    always_comb begin
        merged = state_q;
        if (wr_hit) begin
            merged = SLOT_IDLE;
        end
        if (ld_hit) begin
            merged = ld_fault ? SLOT_DEFERRED : SLOT_ARMED;
        end
    end

    // The check sees the merged state; a pass consumes the record (R6, R7)
    always_comb begin
        unique case (merged)
            SLOT_IDLE:     state_d = SLOT_IDLE;
            SLOT_ARMED:    state_d = chk_hit ? SLOT_IDLE : SLOT_ARMED;
            SLOT_DEFERRED: state_d = SLOT_DEFERRED;
            default:       state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign merged_o = merged;

endmodule

// File: rtl/chk_resolve.sv
module chk_resolve
    import spec_trk_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32,
    localparam int NREGS = 1 << REG_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chk_valid,
    input  logic [REG_W-1:0]              chk_reg,
    input  logic [ADDR_W-1:0]             chk_target,
    input  slot_state_e [NREGS-1:0]       merged,
    output logic                          chk_pass,
    output logic                          chk_redirect,
    output logic [ADDR_W-1:0]             redirect_addr,
    output logic                          chk_orphan
);

    slot_state_e        sel;
    chk_result_e        result_d;
    chk_result_e        result_q;
    logic [ADDR_W-1:0]  addr_q;

    assign sel = merged[chk_reg];

    always_comb begin
        if (!chk_valid) begin
            result_d = RES_NONE;
        end else begin
            unique case (sel)
                SLOT_IDLE:     result_d = RES_ORPHAN;
                SLOT_ARMED:    result_d = RES_PASS;
                SLOT_DEFERRED: result_d = RES_REDIRECT;
                default:       result_d = RES_ORPHAN;
            endcase
        end
    end

    // Output register: the result lasts one cycle and the address is gated
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= RES_NONE;
            addr_q   <= '0;
        end else begin
            result_q <= result_d;
            addr_q   <= (result_d == RES_REDIRECT) ? chk_target : '0;
        end
    end

    assign chk_pass      = (result_q == RES_PASS);
    assign chk_redirect  = (result_q == RES_REDIRECT);
    assign chk_orphan    = (result_q == RES_ORPHAN);
    assign redirect_addr = addr_q;

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
    import spec_trk_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_done_valid,
    input  logic [REG_W-1:0]  ld_done_reg,
    input  logic              ld_done_fault,
    input  logic              wr_valid,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic [ADDR_W-1:0] chk_target,
    output logic              chk_pass,
    output logic              chk_redirect,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              chk_orphan
);

    localparam int NREGS = 1 << REG_W;

    logic [NREGS-1:0]         ld_hit;
    logic [NREGS-1:0]         wr_hit;
    logic [NREGS-1:0]         chk_hit;
    slot_state_e [NREGS-1:0]  merged;

    reg_index_decoder #(.IDX_W(REG_W)) u_ld_dec (
        .valid (ld_done_valid),
        .idx   (ld_done_reg),
        .hit   (ld_hit)
    );

    reg_index_decoder #(.IDX_W(REG_W)) u_wr_dec (
        .valid (wr_valid),
        .idx   (wr_reg),
        .hit   (wr_hit)
    );

    reg_index_decoder #(.IDX_W(REG_W)) u_chk_dec (
        .valid (chk_valid),
        .idx   (chk_reg),
        .hit   (chk_hit)
    );

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        spec_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit[g]),
            .ld_hit   (ld_hit[g]),
            .ld_fault (ld_done_fault),
            .chk_hit  (chk_hit[g]),
            .merged_o (merged[g])
        );
    end

    chk_resolve #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_resolve (
        .clk           (clk),
        .rst_n         (rst_n),
        .chk_valid     (chk_valid),
        .chk_reg       (chk_reg),
        .chk_target    (chk_target),
        .merged        (merged),
        .chk_pass      (chk_pass),
        .chk_redirect  (chk_redirect),
        .redirect_addr (redirect_addr),
        .chk_orphan    (chk_orphan)
    );

endmodule

// File: rtl/spec_load_tracker_chk.sv
module spec_load_tracker_chk #(
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_done_valid,
    input logic [REG_W-1:0]  ld_done_reg,
    input logic              ld_done_fault,
    input logic              wr_valid,
    input logic [REG_W-1:0]  wr_reg,
    input logic              chk_valid,
    input logic [REG_W-1:0]  chk_reg,
    input logic [ADDR_W-1:0] chk_target,
    input logic              chk_pass,
    input logic              chk_redirect,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              chk_orphan
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !(chk_pass || chk_redirect || chk_orphan) && redirect_addr == '0);

    p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> $countones({chk_pass, chk_redirect, chk_orphan}) == 1);

    p_no_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !(chk_pass || chk_redirect || chk_orphan));

    p_redirect_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_redirect |-> redirect_addr == $past(chk_target));

    p_addr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_redirect |-> redirect_addr == '0);

    p_load_fault_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && ld_done_valid && ld_done_reg == chk_reg && ld_done_fault)
        |=> chk_redirect);

    p_load_clean_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && ld_done_valid && ld_done_reg == chk_reg && !ld_done_fault)
        |=> chk_pass);

    p_write_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && wr_valid && wr_reg == chk_reg &&
         !(ld_done_valid && ld_done_reg == chk_reg))
        |=> chk_orphan);

endmodule

bind spec_load_tracker spec_load_tracker_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_done_valid (ld_done_valid),
    .ld_done_reg   (ld_done_reg),
    .ld_done_fault (ld_done_fault),
    .wr_valid      (wr_valid),
    .wr_reg        (wr_reg),
    .chk_valid     (chk_valid),
    .chk_reg       (chk_reg),
    .chk_target    (chk_target),
    .chk_pass      (chk_pass),
    .chk_redirect  (chk_redirect),
    .redirect_addr (redirect_addr),
    .chk_orphan    (chk_orphan)
);

// File: tb/tb_spec_load_tracker.sv
module tb_spec_load_tracker;

    localparam int REG_W  = 5;
    localparam int ADDR_W = 32;

    // Expected outcome, packed as {pass, redirect, orphan}
    localparam logic [2:0] E_NONE = 3'b000;
    localparam logic [2:0] E_PASS = 3'b100;
    localparam logic [2:0] E_RDR  = 3'b010;
    localparam logic [2:0] E_ORPH = 3'b001;

    typedef struct packed {
        logic              ld_v;
        logic [REG_W-1:0]  ld_r;
        logic              ld_f;
        logic              wr_v;
        logic [REG_W-1:0]  wr_r;
        logic              chk_v;
        logic [REG_W-1:0]  chk_r;
        logic [ADDR_W-1:0] tgt;
        logic [2:0]        exp;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3,  1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd12}, // R12 no check
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd3,  32'h100, E_PASS, 4'd2},  // R2
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd3,  32'h104, E_ORPH, 4'd6},  // R6
        '{1'b1, 5'd5,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd12}, // R12
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd5,  32'h200, E_RDR,  4'd3},  // R3
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd5,  32'h240, E_RDR,  4'd7},  // R7
        '{1'b0, 5'd0,  1'b0, 1'b1, 5'd5,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd5},  // R5 write
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd5,  32'h280, E_ORPH, 4'd5},  // R5
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd9,  32'h2c0, E_ORPH, 4'd4},  // R4
        '{1'b1, 5'd7,  1'b1, 1'b0, 5'd0,  1'b1, 5'd7,  32'h300, E_RDR,  4'd8},  // R8 fault
        '{1'b1, 5'd8,  1'b0, 1'b0, 5'd0,  1'b1, 5'd8,  32'h340, E_PASS, 4'd8},  // R8 clean
        '{1'b1, 5'd10, 1'b1, 1'b1, 5'd10, 1'b0, 5'd0,  32'h0,   E_NONE, 4'd9},  // R9
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd10, 32'h3c0, E_RDR,  4'd9},  // R9
        '{1'b1, 5'd11, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd10}, // R10
        '{1'b0, 5'd0,  1'b0, 1'b1, 5'd11, 1'b1, 5'd11, 32'h400, E_ORPH, 4'd10}, // R10
        '{1'b1, 5'd12, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd13}, // R13
        '{1'b1, 5'd12, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd13}, // R13
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd12, 32'h440, E_PASS, 4'd13}, // R13
        '{1'b1, 5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd11}, // R11
        '{1'b1, 5'd2,  1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  32'h0,   E_NONE, 4'd11}, // R11
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd2,  32'h480, E_PASS, 4'd11}, // R11
        '{1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd1,  32'h4c0, E_RDR,  4'd11}  // R11
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ld_done_valid;
    logic [REG_W-1:0]  ld_done_reg;
    logic              ld_done_fault;
    logic              wr_valid;
    logic [REG_W-1:0]  wr_reg;
    logic              chk_valid;
    logic [REG_W-1:0]  chk_reg;
    logic [ADDR_W-1:0] chk_target;
    logic              chk_pass;
    logic              chk_redirect;
    logic [ADDR_W-1:0] redirect_addr;
    logic              chk_orphan;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spec_load_tracker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_done_valid (ld_done_valid),
        .ld_done_reg   (ld_done_reg),
        .ld_done_fault (ld_done_fault),
        .wr_valid      (wr_valid),
        .wr_reg        (wr_reg),
        .chk_valid     (chk_valid),
        .chk_reg       (chk_reg),
        .chk_target    (chk_target),
        .chk_pass      (chk_pass),
        .chk_redirect  (chk_redirect),
        .redirect_addr (redirect_addr),
        .chk_orphan    (chk_orphan)
    );

    task automatic expect_out(input string tag, input logic [2:0] exp,
                              input logic [ADDR_W-1:0] exp_addr);
        logic [2:0] got;
        got = {chk_pass, chk_redirect, chk_orphan};
        checks++;
        if (got !== exp || redirect_addr !== exp_addr) begin
            errors++;
            $display("FAIL %s: got out=%b addr=%h expected out=%b addr=%h",
                     tag, got, redirect_addr, exp, exp_addr);
        end
    endtask

    task automatic idle_inputs();
        ld_done_valid = 1'b0; ld_done_reg = '0; ld_done_fault = 1'b0;
        wr_valid = 1'b0; wr_reg = '0;
        chk_valid = 1'b0; chk_reg = '0; chk_target = '0;
    endtask

    task automatic apply(input vec_t v);
        ld_done_valid = v.ld_v; ld_done_reg = v.ld_r; ld_done_fault = v.ld_f;
        wr_valid = v.wr_v; wr_reg = v.wr_r;
        chk_valid = v.chk_v; chk_reg = v.chk_r; chk_target = v.tgt;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no completion expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        expect_out("R1 outputs during reset", E_NONE, '0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 outputs after reset", E_NONE, '0);

        // R1: a fresh register is clean
        chk_valid = 1'b1; chk_reg = 5'd3; chk_target = 32'h50;
        @(negedge clk);
        expect_out("R1 check after reset", E_ORPH, '0);
        idle_inputs();

        // Vector table: outcome of each row appears one cycle later
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            apply(v);
            @(negedge clk);
            expect_out($sformatf("R%0d row %0d", v.req, i), v.exp,
                       (v.exp == E_RDR) ? v.tgt : '0);
        end
        idle_inputs();
        @(negedge clk);
        expect_out("R12 quiet after table", E_NONE, '0);

        // R1: reset wipes a faulted register
        ld_done_valid = 1'b1; ld_done_reg = 5'd4; ld_done_fault = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk_valid = 1'b1; chk_reg = 5'd4; chk_target = 32'h600;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_out("R1 outputs held in reset", E_NONE, '0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 faulted register cleared by reset", E_ORPH, '0);
        idle_inputs();
        @(negedge clk);
        expect_out("R3 address returns to zero", E_NONE, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule